// File: doc/BRIEF.md
# Compressed Branch and Link Unit

This block resolves the branch-type instructions of a 16-bit compressed instruction set in a single step. It covers four kinds of branch: the conditional branch with an 8-bit offset, the unconditional branch with an 11-bit offset, and the call that is split across two halfwords. The second half of that call comes in a plain form and in a form that switches the instruction state. Each cycle, the pipeline may present a 32-bit fetch word together with the current program counter, the four condition flags, the current link register and a byte-order select. One clock later the block reports the result. The result says whether the instruction was in scope and whether the pipeline must be flushed. It also gives the branch target, any link register write, a request to clear the compressed-state bit, and whether the encoding is undefined.

Both halves of a call may sit in the same fetch word. In that case the block fuses them and produces the final target and return link at once. If the halfword after a first half cannot complete the call, only the intermediate link value is written. Condition codes are evaluated from the flags within the same cycle.

Top module: `cbl_unit`

## Requirements
- R1: With `big_end_i`=1 the current halfword is `fetch_i[31:16]` and the following one is `fetch_i[15:0]`. With `big_end_i`=0 it is the other way round.
- R2: The opcode class is bits [15:11] of a halfword. Classes 26 and 27 with condition field [11:8] below 14 form a conditional branch. When the condition holds, the block flushes and the target is PC+4 plus the sign-extended offset [7:0] times two.
- R3: Flags are `flags_i`[3]=N, [2]=Z, [1]=C, [0]=V. The single-flag conditions are: 0 Z set, 1 Z clear, 2 C set, 3 C clear, 4 N set, 5 N clear, 6 V set, 7 V clear.
- R4: The compound conditions are: 8 true when C is set and Z is clear; 9 true when C is clear or Z is set; 10 true when N equals V; 11 true when N differs from V; 12 true when Z is clear and N equals V; 13 true when Z is set or N differs from V.
- R5: In the conditional class, condition 14 raises undefined and done without a flush. Condition 15, and every class other than 26 to 31, raises nothing at all (done low).
- R6: A conditional branch whose condition fails raises done with no flush.
- R7: Class 28 always flushes. Its target is PC+4 plus the offset [10:0], sign-extended from bit 10 and doubled.
- R8: For a class 30 halfword, the intermediate link value is PC+4 plus the offset [10:0], sign-extended from bit 10 and shifted left by 12. If the next halfword cannot complete the call, the block writes this value to the link register and does not flush.
- R9: If the next halfword is class 31, the call is fused. The target is the intermediate link value plus the next halfword's [10:0] doubled, and the link write is (PC+4) with bit 0 set.
- R10: If the next halfword is class 29 with bit 0 clear, the call is fused the same way. In addition, the target has its low two bits cleared and the clear-state request is raised. If that halfword's bit 0 is set, the block does not fuse and behaves as in R8.
- R11: A standalone class 31 halfword flushes to `lr_i` plus its [10:0] doubled, and writes (PC+2) with bit 0 set to the link register.
- R12: A standalone class 29 halfword with bit 0 clear acts like R11, but its target has the low two bits cleared and it raises clear-state. With bit 0 set it raises only undefined and done.
- R13: Results appear on the outputs in the cycle after `valid_i` is sampled and last one cycle. Without `valid_i`, and after reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Fetch word presented this cycle |
| pc_i | input | 32 | Address of the current halfword |
| fetch_i | input | 32 | Two halfwords: current and following |
| big_end_i | input | 1 | Byte-order select for halfword order |
| flags_i | input | 4 | N, Z, C, V condition flags |
| lr_i | input | 32 | Current link register value |
| done_o | output | 1 | Instruction handled by this unit |
| flush_o | output | 1 | Branch taken, flush pipeline |
| target_o | output | 32 | Branch target address |
| lr_we_o | output | 1 | Link register write enable |
| lr_data_o | output | 32 | Link register write data |
| clr_tstate_o | output | 1 | Clear compressed-state bit |
| undef_o | output | 1 | Undefined encoding |

## Verification
The hardest case to reach is a fused call through the state-switching second half whose sum is not word aligned. Reaching it requires a first-half address that is halfword- but not word-aligned, together with an even low offset, so that the truncation of the two low bits actually changes the target. The stimulus places both halves in one fetch word at PC 0x8002. It then repeats the same pair with bit 0 of the second half set, which must demote the operation to a bare link update. Both halfword orders are driven with the same instruction, so that a swapped select shows up as a different class.

// File: rtl/cbl_pkg.sv
package cbl_pkg;
  parameter int ADDR_W = 32;
  parameter int HW_W   = 16;

  localparam logic [4:0] CLS_COND_A  = 5'd26;
  localparam logic [4:0] CLS_COND_B  = 5'd27;
  localparam logic [4:0] CLS_JUMP    = 5'd28;
  localparam logic [4:0] CLS_CALL_X  = 5'd29;
  localparam logic [4:0] CLS_CALL_HI = 5'd30;
  localparam logic [4:0] CLS_CALL_LO = 5'd31;

  typedef struct packed {
    logic              done;
    logic              flush;
    logic              undef;
    logic              lr_we;
    logic              clr_t;
    logic [ADDR_W-1:0] target;
    logic [ADDR_W-1:0] lr_data;
  } br_res_t;
endpackage

// File: rtl/cbl_half_pick.sv
module cbl_half_pick
  import cbl_pkg::*;
#(
  parameter int HW = HW_W
) (
  input  logic [2*HW-1:0] word_i,
  input  logic            big_i,
  output logic [HW-1:0]   cur_o,
  output logic [HW-1:0]   nxt_o
);
  logic [HW-1:0] upper, lower;
  assign upper = word_i[2*HW-1:HW];
  assign lower = word_i[HW-1:0];
  assign cur_o = big_i ? upper : lower;
  assign nxt_o = big_i ? lower : upper;
endmodule

// File: rtl/cbl_cond_eval.sv
module cbl_cond_eval (
  input  logic [3:0] cond_i,
  input  logic [3:0] flags_i,
  output logic       pass_o
);
  logic fn, fz, fc, fv;
  assign {fn, fz, fc, fv} = flags_i;

  always_comb begin
    unique case (cond_i)
      4'd0:    pass_o = fz;
      4'd1:    pass_o = !fz;
      4'd2:    pass_o = fc;
      4'd3:    pass_o = !fc;
      4'd4:    pass_o = fn;
      4'd5:    pass_o = !fn;
      4'd6:    pass_o = fv;
      4'd7:    pass_o = !fv;
      4'd8:    pass_o = fc && !fz;
      4'd9:    pass_o = !fc || fz;
      4'd10:   pass_o = (fn == fv);
      4'd11:   pass_o = (fn != fv);
      4'd12:   pass_o = !fz && (fn == fv);
      4'd13:   pass_o = fz || (fn != fv);
      default: pass_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/cbl_decode.sv
module cbl_decode
  import cbl_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int HW = HW_W
) (
  input  logic [HW-1:0] cur_i,
  input  logic [HW-1:0] nxt_i,
  input  logic [AW-1:0] pc_i,
  input  logic [AW-1:0] lr_i,
  input  logic          pass_i,
  output br_res_t       res_o
);
  localparam int OFF8_EXT  = AW - 9;
  localparam int OFF11_EXT = AW - 12;
  localparam int HI_EXT    = AW - 23;

  logic [4:0]    cls, ncls;
  logic [AW-1:0] pc_p2, pc_p4, off8, off11, hi_off, lo_cur, lo_nxt, mid_lr;
  logic [AW-1:0] fuse_sum, solo_sum;

  assign cls    = cur_i[15:11];
  assign ncls   = nxt_i[15:11];
  assign pc_p2  = pc_i + AW'(2);
  assign pc_p4  = pc_i + AW'(4);
  assign off8   = {{OFF8_EXT{cur_i[7]}}, cur_i[7:0], 1'b0};
  assign off11  = {{OFF11_EXT{cur_i[10]}}, cur_i[10:0], 1'b0};
  assign hi_off = {{HI_EXT{cur_i[10]}}, cur_i[10:0], 12'b0};
  assign lo_cur = {{OFF11_EXT{1'b0}}, cur_i[10:0], 1'b0};
  assign lo_nxt = {{OFF11_EXT{1'b0}}, nxt_i[10:0], 1'b0};
  assign mid_lr = pc_p4 + hi_off;
  assign fuse_sum = mid_lr + lo_nxt;
  assign solo_sum = lr_i + lo_cur;

  always_comb begin
    res_o = '0;
    unique case (cls)
      CLS_COND_A, CLS_COND_B: begin
        if (cur_i[11:8] == 4'hE) begin
          res_o.done  = 1'b1;
          res_o.undef = 1'b1;
        end else if (cur_i[11:8] != 4'hF) begin
          res_o.done   = 1'b1;
          res_o.flush  = pass_i;
          res_o.target = pc_p4 + off8;
        end
      end
      CLS_JUMP: begin
        res_o.done   = 1'b1;
        res_o.flush  = 1'b1;
        res_o.target = pc_p4 + off11;
      end
      CLS_CALL_HI: begin
        res_o.done  = 1'b1;
        res_o.lr_we = 1'b1;
        if (ncls == CLS_CALL_LO) begin
          res_o.flush   = 1'b1;
          res_o.target  = fuse_sum;
          res_o.lr_data = {pc_p4[AW-1:1], 1'b1};
        end else if (ncls == CLS_CALL_X && !nxt_i[0]) begin
          res_o.flush   = 1'b1;
          res_o.clr_t   = 1'b1;
          res_o.target  = {fuse_sum[AW-1:2], 2'b00};
          res_o.lr_data = {pc_p4[AW-1:1], 1'b1};
        end else begin
          res_o.lr_data = mid_lr;
        end
      end
      CLS_CALL_LO: begin
        res_o.done    = 1'b1;
        res_o.flush   = 1'b1;
        res_o.lr_we   = 1'b1;
        res_o.target  = solo_sum;
        res_o.lr_data = {pc_p2[AW-1:1], 1'b1};
      end
      CLS_CALL_X: begin
        res_o.done = 1'b1;
        if (cur_i[0]) begin
          res_o.undef = 1'b1;
        end else begin
          res_o.flush   = 1'b1;
          res_o.lr_we   = 1'b1;
          res_o.clr_t   = 1'b1;
          res_o.target  = {solo_sum[AW-1:2], 2'b00};
          res_o.lr_data = {pc_p2[AW-1:1], 1'b1};
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/cbl_unit.sv
module cbl_unit
  import cbl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [2*HW_W-1:0] fetch_i,
  input  logic              big_end_i,
  input  logic [3:0]        flags_i,
  input  logic [ADDR_W-1:0] lr_i,
  output logic              done_o,
  output logic              flush_o,
  output logic [ADDR_W-1:0] target_o,
  output logic              lr_we_o,
  output logic [ADDR_W-1:0] lr_data_o,
  output logic              clr_tstate_o,
  output logic              undef_o
);
  logic [1:0]      rst_sync_q;
  logic            rst_ok;
  logic [HW_W-1:0] cur_hw, nxt_hw;
  logic            cond_pass;
  br_res_t         res_d, res_q, res_nx;
  logic            valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ok = rst_sync_q[1];

  cbl_half_pick #(.HW(HW_W)) u_pick (
    .word_i(fetch_i), .big_i(big_end_i), .cur_o(cur_hw), .nxt_o(nxt_hw)
  );

  cbl_cond_eval u_cond (
    .cond_i(cur_hw[11:8]), .flags_i(flags_i), .pass_o(cond_pass)
  );

  cbl_decode #(.AW(ADDR_W), .HW(HW_W)) u_dec (
    .cur_i(cur_hw), .nxt_i(nxt_hw), .pc_i(pc_i), .lr_i(lr_i),
    .pass_i(cond_pass), .res_o(res_d)
  );

  always_comb begin
    res_nx = res_q;
    if (valid_i) res_nx = res_d;
    else         res_nx = '0;
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      res_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      res_q   <= res_nx;
      valid_q <= valid_i;
    end
  end

  assign done_o       = res_q.done;
  assign flush_o      = res_q.flush;
  assign undef_o      = res_q.undef;
  assign lr_we_o      = res_q.lr_we;
  assign clr_tstate_o = res_q.clr_t;
  assign target_o     = res_q.target;
  assign lr_data_o    = res_q.lr_data;

  p_flush_done_r13: assert property (@(posedge clk) disable iff (!rst_ok)
    flush_o |-> done_o);
  p_idle_quiet_r13: assert property (@(posedge clk) disable iff (!rst_ok)
    !valid_q |-> !done_o && !flush_o && !lr_we_o);
  p_undef_no_flush_r5: assert property (@(posedge clk) disable iff (!rst_ok)
    undef_o |-> !flush_o && !lr_we_o && !clr_tstate_o);
  p_clr_aligned_r10: assert property (@(posedge clk) disable iff (!rst_ok)
    clr_tstate_o |-> flush_o && lr_we_o && (target_o[1:0] == 2'b00));
  p_link_odd_r9: assert property (@(posedge clk) disable iff (!rst_ok)
    (lr_we_o && flush_o) |-> lr_data_o[0]);
  p_pulse_r13: assert property (@(posedge clk) disable iff (!rst_ok)
    (flush_o && !valid_i) |=> !flush_o);
endmodule

// File: tb/cbl_unit_test.sv
`timescale 1ns/1ps
module cbl_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] pc_i = '0, fetch_i = '0, lr_i = '0;
  logic        big_end_i = 1'b0;
  logic [3:0]  flags_i = '0;
  logic        done_o, flush_o, lr_we_o, clr_tstate_o, undef_o;
  logic [31:0] target_o, lr_data_o;

  int n_vec = 0, n_bad = 0;
  bit finished = 0;
  logic [68:0] q_exp[$];
  string       q_tag[$];

  always #2 clk = ~clk;

  cbl_unit uut (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .pc_i(pc_i),
    .fetch_i(fetch_i), .big_end_i(big_end_i), .flags_i(flags_i),
    .lr_i(lr_i), .done_o(done_o), .flush_o(flush_o), .target_o(target_o),
    .lr_we_o(lr_we_o), .lr_data_o(lr_data_o), .clr_tstate_o(clr_tstate_o),
    .undef_o(undef_o)
  );

  // expected: {done,flush,undef,lr_we,clr,target,lr_data}
  task automatic apply(input string tag, input logic v, input logic [31:0] pc,
                       input logic [31:0] fw, input logic be, input logic [3:0] fl,
                       input logic [31:0] lr, input logic e_done, input logic e_fl,
                       input logic e_und, input logic e_we, input logic e_clr,
                       input logic [31:0] e_tgt, input logic [31:0] e_lr);
    @(negedge clk);
    valid_i = v; pc_i = pc; fetch_i = fw; big_end_i = be; flags_i = fl; lr_i = lr;
    q_exp.push_back({e_done, e_fl, e_und, e_we, e_clr, e_tgt, e_lr});
    q_tag.push_back(tag);
  endtask

  task automatic idle();
    apply("R13 idle", 1'b0, 32'h0, 32'h0, 1'b0, 4'h0, 32'h0, 0, 0, 0, 0, 0, 32'h0, 32'h0);
  endtask

  always @(posedge clk) begin
    #1;
    if (q_exp.size() > 0) begin
      logic [68:0] e;
      string t;
      logic ok;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      ok = (done_o == e[68]) && (flush_o == e[67]) && (undef_o == e[66]) &&
           (lr_we_o == e[65]) && (clr_tstate_o == e[64]) &&
           (!e[67] || target_o == e[63:32]) && (!e[65] || lr_data_o == e[31:0]);
      n_vec++;
      if (!ok) begin
        n_bad++;
        $display("FAIL %s: got d%b f%b u%b w%b c%b tgt %h lr %h, exp d%b f%b u%b w%b c%b tgt %h lr %h",
                 t, done_o, flush_o, undef_o, lr_we_o, clr_tstate_o, target_o, lr_data_o,
                 e[68], e[67], e[66], e[65], e[64], e[63:32], e[31:0]);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 20000);
    n_vec++; n_bad++;
    $display("FAIL watchdog: got hung run, exp completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    n_vec++;
    if (done_o || flush_o || lr_we_o || clr_tstate_o || undef_o) begin
      n_bad++;
      $display("FAIL R13 reset: got outputs active, exp all zero");
    end
    // R1 halfword order
    apply("R1 little", 1, 32'h1000, 32'hD000_E005, 0, 4'h0, 0, 1,1,0,0,0, 32'h100E, 0);
    apply("R1 big",    1, 32'h1000, 32'hE005_D000, 1, 4'h0, 0, 1,1,0,0,0, 32'h100E, 0);
    apply("R1 swap",   1, 32'h2000, 32'hE005_D3FF, 0, 4'h0, 0, 1,1,0,0,0, 32'h2002, 0);
    // R2/R3 conditional taken
    apply("R2 eq",     1, 32'h0100, 32'h0000_D010, 0, 4'b0100, 0, 1,1,0,0,0, 32'h0124, 0);
    apply("R2 negoff", 1, 32'h1000, 32'h0000_D080, 0, 4'b0100, 0, 1,1,0,0,0, 32'h0F04, 0);
    apply("R3 ne",     1, 32'h0100, 32'h0000_D102, 0, 4'b0000, 0, 1,1,0,0,0, 32'h0108, 0);
    apply("R3 cs",     1, 32'h0100, 32'h0000_D202, 0, 4'b0010, 0, 1,1,0,0,0, 32'h0108, 0);
    apply("R3 mi",     1, 32'h0100, 32'h0000_D402, 0, 4'b1000, 0, 1,1,0,0,0, 32'h0108, 0);
    apply("R3 pl",     1, 32'h0100, 32'h0000_D502, 0, 4'b0000, 0, 1,1,0,0,0, 32'h0108, 0);
    apply("R3 vs",     1, 32'h0100, 32'h0000_D602, 0, 4'b0001, 0, 1,1,0,0,0, 32'h0108, 0);
    apply("R3 vc no",  1, 32'h0100, 32'h0000_D702, 0, 4'b0001, 0, 1,0,0,0,0, 0, 0);
    // R6 not taken
    apply("R6 eq no",  1, 32'h0100, 32'h0000_D010, 0, 4'b0000, 0, 1,0,0,0,0, 0, 0);
    // R4 compound
    apply("R4 hi",     1, 32'h0100, 32'h0000_D802, 0, 4'b0010, 0, 1,1,0,0,0, 32'h0108, 0);
    apply("R4 hi no",  1, 32'h0100, 32'h0000_D802, 0, 4'b0110, 0, 1,0,0,0,0, 0, 0);
    apply("R4 ls",     1, 32'h0100, 32'h0000_D902, 0, 4'b0000, 0, 1,1,0,0,0, 32'h0108, 0);
    apply("R4 ge",     1, 32'h0100, 32'h0000_DA02, 0, 4'b1001, 0, 1,1,0,0,0, 32'h0108, 0);
    apply("R4 ge no",  1, 32'h0100, 32'h0000_DA02, 0, 4'b1000, 0, 1,0,0,0,0, 0, 0);
    apply("R4 lt",     1, 32'h0100, 32'h0000_DB02, 0, 4'b1000, 0, 1,1,0,0,0, 32'h0108, 0);
    apply("R4 gt",     1, 32'h0100, 32'h0000_DC02, 0, 4'b1001, 0, 1,1,0,0,0, 32'h0108, 0);
    apply("R4 gt no",  1, 32'h0100, 32'h0000_DC02, 0, 4'b1101, 0, 1,0,0,0,0, 0, 0);
    apply("R4 le z",   1, 32'h0100, 32'h0000_DD02, 0, 4'b0100, 0, 1,1,0,0,0, 32'h0108, 0);
    apply("R4 le nv",  1, 32'h0100, 32'h0000_DD02, 0, 4'b0001, 0, 1,1,0,0,0, 32'h0108, 0);
    apply("R4 le no",  1, 32'h0100, 32'h0000_DD02, 0, 4'b1001, 0, 1,0,0,0,0, 0, 0);
    // R5 undefined / out of scope
    apply("R5 c14",    1, 32'h0100, 32'h0000_DE00, 0, 4'hF, 0, 1,0,1,0,0, 0, 0);
    apply("R5 c15",    1, 32'h0100, 32'h0000_DF12, 0, 4'hF, 0, 0,0,0,0,0, 0, 0);
    apply("R5 other",  1, 32'h0100, 32'h0000_4770, 0, 4'hF, 0, 0,0,0,0,0, 0, 0);
    // R7 unconditional
    apply("R7 neg1",   1, 32'h3000, 32'h0000_E7FF, 0, 4'h0, 0, 1,1,0,0,0, 32'h3002, 0);
    apply("R7 min",    1, 32'h4000, 32'h0000_E400, 0, 4'h0, 0, 1,1,0,0,0, 32'h3804, 0);
    // R8 first half alone
    apply("R8 pos",    1, 32'h8000, 32'h0000_F001, 0, 4'h0, 0, 1,0,0,1,0, 0, 32'h9004);
    apply("R8 neg",    1, 32'h8000, 32'h0000_F7FF, 0, 4'h0, 0, 1,0,0,1,0, 0, 32'h7004);
    // R9 fused plain
    apply("R9 fuse",   1, 32'h8000, 32'hF810_F001, 0, 4'h0, 0, 1,1,0,1,0, 32'h9024, 32'h8005);
    apply("R9 fuse be",1, 32'h8000, 32'hF001_F810, 1, 4'h0, 0, 1,1,0,1,0, 32'h9024, 32'h8005);
    // R10 fused exchange
    apply("R10 fuse",  1, 32'h8002, 32'hE810_F001, 0, 4'h0, 0, 1,1,0,1,1, 32'h9024, 32'h8007);
    apply("R10 odd",   1, 32'h8002, 32'hE811_F001, 0, 4'h0, 0, 1,0,0,1,0, 0, 32'h9006);
    // R11 standalone second half
    apply("R11 solo",  1, 32'h0500, 32'h0000_F805, 0, 4'h0, 32'h4000, 1,1,0,1,0, 32'h400A, 32'h0503);
    // R12 standalone exchange
    apply("R12 solo",  1, 32'h0600, 32'h0000_E806, 0, 4'h0, 32'h4002, 1,1,0,1,1, 32'h400C, 32'h0603);
    apply("R12 odd",   1, 32'h0600, 32'h0000_E807, 0, 4'h0, 32'h4002, 1,0,1,0,0, 0, 0);
    // R13 single-cycle pulse, then quiet
    apply("R13 pulse", 1, 32'h3000, 32'h0000_E7FF, 0, 4'h0, 0, 1,1,0,0,0, 32'h3002, 0);
    idle();
    idle();
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule